// File: doc/BRIEF.md
# Smart-Card Asynchronous Serial Transceiver

This block sends and receives asynchronous characters in the form smart-card links use. Each character is one start bit, eight data bits, a parity bit and a single stop bit. The line idles high. A single configuration input chooses between two conventions. The direct convention sends data least significant bit first, with even parity and plain line levels. The inverse convention sends data most significant bit first, with odd parity, and inverts the data and parity bits on the wire. The transmitter has a one-character holding register in front of its shift register. The receiver oversamples the line at sixteen times the bit rate and keeps one received character in a buffer.

The bit rate comes from a prescaler and an 8-bit divisor. The prescaler passes the clock through, or divides it by an even amount. When a received character fails its parity check, the block pulls its transmit line low for one bit time, starting partway into the stop bit. This tells the far end to resend. After the pulse, the transmitter waits out one more bit time before it may start a frame. Error flags and one-cycle interrupt pulses report completed transfers.

Top module: `card_uart`

## Requirements
- R1: One bit lasts P×(m+1)×16 clock cycles. m is `baud_div`. P is 1 when `baud_pre` is 0, and 2×`baud_pre` otherwise.
- R2: A frame is sent in this order: start (line 0), eight data bits, parity, stop (line 1). The line rests at 1 when no frame is being sent.
- R3: With `conv_inverse`=0, data goes out least significant bit first. The parity bit makes the count of ones over data and parity even. Line levels equal the logical values.
- R4: With `conv_inverse`=1, data goes out most significant bit first. The parity bit makes the count of logical ones over data and parity odd. The data and parity bits are inverted on the line; start and stop are not.
- R5: A frame starts only while `tx_enable`=1 and the holding register is full. `tx_ready`=1 means the holding register is empty. A `tx_write` while `tx_ready`=0 is ignored. `tx_irq` pulses for one cycle when the stop bit has been fully sent.
- R6: Reception starts only while `rx_enable`=1 and a low level is seen on the line. The start is abandoned unless the vote at mid-bit confirms it. Each bit takes the majority of three consecutive oversamples around its centre.
- R7: When a character completes, it is written to `rx_data`, `rx_valid` is set and `rx_irq` pulses for one cycle. `rx_read` clears `rx_valid`.
- R8: On a parity failure, `err_parity` is set and `line_out` is held at 0 for 16 oversample ticks, starting from the stop-bit vote. No transmit frame may start from the parity sample until one bit time after the pulse ends.
- R9: `err_frame` is set when the stop bit is voted 0.
- R10: A character that completes while `rx_valid`=1 and no `rx_read` is given in that cycle sets `err_overrun`. No `rx_irq` is raised for it, and `rx_valid` stays 1.
- R11: `err_sum` is the OR of the three error flags. All three flags are rewritten at every character completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_inverse | input | 1 | 0 selects the direct convention, 1 the inverse convention |
| baud_pre | input | 4 | Prescaler select: 0 passes the clock through, n divides it by 2n |
| baud_div | input | 8 | Divisor value m |
| tx_enable | input | 1 | Allows frames to start |
| tx_write | input | 1 | Loads `tx_data` into the holding register |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Holding register empty |
| rx_enable | input | 1 | Allows reception to start |
| rx_read | input | 1 | Acknowledges the received character |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Receive buffer holds an unread character |
| line_in | input | 1 | Serial receive line |
| line_out | output | 1 | Serial transmit line, including the parity error pulse |
| tx_irq | output | 1 | Transmit done pulse |
| rx_irq | output | 1 | Receive done pulse |
| err_overrun | output | 1 | Overrun on the last completion |
| err_frame | output | 1 | Framing error on the last completion |
| err_parity | output | 1 | Parity error on the last completion |
| err_sum | output | 1 | OR of the error flags |

## Verification
The two functions that can overlap are the receiver's parity-error pulse and the transmitter's start of a new frame. Both drive `line_out`. To make them meet, the bench sends a received character with a corrupted parity bit. It writes a transmit character in the stop-bit slot, while the failure is already known and before the pulse begins. The bench then measures the first low run on `line_out`, which must be exactly one bit long. It measures the high gap that follows, which must be at least one bit long. Finally it decodes the frame that comes after and compares it with the character that was written.

// File: rtl/card_uart_pkg.sv
package card_uart_pkg;
  localparam int OSR      = 16;
  localparam int OSR_W    = $clog2(OSR);
  localparam int CHAR_W   = 8;
  localparam int FRAME_W  = CHAR_W + 3;
  localparam int RXBITS_W = CHAR_W + 1;

  // source-clock period in input clocks for a prescaler select value
  function automatic logic [4:0] pre_period(input logic [3:0] sel);
    return (sel == 4'd0) ? 5'd1 : {sel, 1'b0};
  endfunction

  function automatic logic [CHAR_W-1:0] flip(input logic [CHAR_W-1:0] d);
    logic [CHAR_W-1:0] r;
    for (int i = 0; i < CHAR_W; i++) r[i] = d[CHAR_W-1-i];
    return r;
  endfunction

  // line image of a frame, element 0 goes out first
  function automatic logic [FRAME_W-1:0] frame_of(input logic [CHAR_W-1:0] d, input logic inv);
    logic [CHAR_W-1:0] body;
    body = inv ? ~flip(d) : d;
    // inverting eight bits keeps their xor, so the wire parity bit is the xor of the body
    return {1'b1, ^body, body, 1'b0};
  endfunction

  // character from the line image of data bits, first received in bit 0
  function automatic logic [CHAR_W-1:0] char_of(input logic [CHAR_W-1:0] body, input logic inv);
    return inv ? flip(~body) : body;
  endfunction

  // over data plus parity the wire xor is zero for a good character in both conventions
  function automatic logic parity_bad(input logic [RXBITS_W-1:0] bits);
    return ^bits;
  endfunction
endpackage

// File: rtl/card_baud.sv
module card_baud #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [DIV_W-1:0] div_val,
  output logic             os_tick
);
  import card_uart_pkg::*;
  logic [4:0]       pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             src_tick;

  assign src_tick = (pre_cnt == pre_period(pre_sel) - 5'd1);
  assign os_tick  = src_tick && (div_cnt == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= src_tick ? 5'd0 : pre_cnt + 5'd1;
      if (src_tick) div_cnt <= os_tick ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_tx.sv
module card_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       inv,
  input  logic       enable,
  input  logic       block,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       ready,
  output logic       line,
  output logic       done,
  output logic       start_evt,
  output logic       busy
);
  import card_uart_pkg::*;
  logic [CHAR_W-1:0]  hold;
  logic               hold_full;
  logic [FRAME_W-1:0] sh;
  logic [OSR_W-1:0]   oscnt;
  logic [3:0]         bitn;
  logic               bit_end;

  assign start_evt = os_tick && !busy && hold_full && enable && !block;
  assign bit_end   = busy && os_tick && (oscnt == OSR_W'(OSR-1));
  assign ready     = !hold_full;
  assign line      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; sh <= '1;
      oscnt <= '0; bitn <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done      <= 1'b0;
      hold_full <= (hold_full && !start_evt) || (wr && !hold_full);
      if (wr && !hold_full) hold <= wdata;
      if (start_evt) begin
        sh    <= frame_of(hold, inv);
        busy  <= 1'b1;
        oscnt <= '0;
        bitn  <= '0;
      end else if (busy && os_tick) begin
        oscnt <= oscnt + 1'b1;
        if (bit_end) begin
          if (bitn == 4'(FRAME_W-1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            bitn <= bitn + 4'd1;
          end
        end
      end
    end
  end

  AST_TX_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(enable)); // R5
endmodule

// File: rtl/card_rx.sv
module card_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       inv,
  input  logic       enable,
  input  logic       line,
  input  logic       rd,
  output logic [7:0] data,
  output logic       valid,
  output logic       irq,
  output logic       e_ovr,
  output logic       e_frm,
  output logic       e_par,
  output logic       pulse_low,
  output logic       tx_block
);
  import card_uart_pkg::*;
  logic                s1, s2, v0, v1, run, par_pend, maj;
  logic [OSR_W-1:0]    oscnt;
  logic [3:0]          bitidx;
  logic [RXBITS_W-1:0] sh, sh_next;
  logic [4:0]          pcnt;
  logic                vote_evt, done_evt, ovr_evt;

  assign maj       = (v0 & v1) | (v0 & s2) | (v1 & s2);
  assign vote_evt  = os_tick && run && (oscnt == OSR_W'(OSR/2 + 1));
  assign done_evt  = vote_evt && (bitidx == 4'(FRAME_W-1));
  assign ovr_evt   = done_evt && valid && !rd;
  assign sh_next   = {maj, sh[RXBITS_W-1:1]};
  assign pulse_low = (pcnt != 5'd0) && (pcnt <= 5'(OSR));
  assign tx_block  = par_pend || (pcnt != 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; v0 <= 1'b1; v1 <= 1'b1; run <= 1'b0;
      oscnt <= '0; bitidx <= '0; sh <= '0; par_pend <= 1'b0; pcnt <= '0;
      data <= '0; valid <= 1'b0; irq <= 1'b0;
      e_ovr <= 1'b0; e_frm <= 1'b0; e_par <= 1'b0;
    end else begin
      s1  <= line;
      s2  <= s1;
      irq <= 1'b0;
      if (os_tick && pcnt != 5'd0) pcnt <= pcnt + 5'd1;
      if (rd) valid <= 1'b0;
      if (os_tick) begin
        if (!run) begin
          if (enable && !s2) begin
            run <= 1'b1; oscnt <= OSR_W'(1); bitidx <= '0;
          end
        end else begin
          oscnt <= oscnt + 1'b1;
          if (oscnt == OSR_W'(OSR/2 - 1)) v0 <= s2;
          if (oscnt == OSR_W'(OSR/2))     v1 <= s2;
          if (oscnt == OSR_W'(OSR-1))     bitidx <= bitidx + 4'd1;
        end
      end
      if (vote_evt) begin
        if (bitidx == 4'd0) begin
          if (maj) run <= 1'b0;
        end else if (!done_evt) begin
          sh <= sh_next;
          if (bitidx == 4'(RXBITS_W) && parity_bad(sh_next)) par_pend <= 1'b1;
        end else begin
          run      <= 1'b0;
          e_frm    <= !maj;
          e_par    <= par_pend;
          par_pend <= 1'b0;
          if (par_pend) pcnt <= 5'd1;
          e_ovr    <= ovr_evt;
          if (!ovr_evt) begin
            data  <= char_of(sh[CHAR_W-1:0], inv);
            valid <= 1'b1;
            irq   <= 1'b1;
          end
        end
      end
    end
  end

  AST_RX_VALID_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid) |-> irq); // R7
  AST_OVR_SILENT: assert property (@(posedge clk) disable iff (!rst_n) e_ovr |-> !irq); // R10
  AST_PULSE_AFTER_PARITY: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_low) |-> e_par); // R8
endmodule

// File: rtl/card_uart.sv
module card_uart #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_inverse,
  input  logic [PRE_W-1:0] baud_pre,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tx_enable,
  input  logic             tx_write,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  input  logic             rx_enable,
  input  logic             rx_read,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             line_in,
  output logic             line_out,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             err_overrun,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_sum
);
  logic os_tick, tx_line, tx_start, tx_busy, rx_pulse_low, tx_block;

  card_baud #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .pre_sel(baud_pre), .div_val(baud_div), .os_tick(os_tick)
  );

  card_tx u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .inv(conv_inverse), .enable(tx_enable),
    .block(tx_block), .wr(tx_write), .wdata(tx_data), .ready(tx_ready), .line(tx_line),
    .done(tx_irq), .start_evt(tx_start), .busy(tx_busy)
  );

  card_rx u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .inv(conv_inverse), .enable(rx_enable),
    .line(line_in), .rd(rx_read), .data(rx_data), .valid(rx_valid), .irq(rx_irq),
    .e_ovr(err_overrun), .e_frm(err_frame), .e_par(err_parity),
    .pulse_low(rx_pulse_low), .tx_block(tx_block)
  );

  assign line_out = tx_line & ~rx_pulse_low;
  assign err_sum  = err_overrun | err_frame | err_parity;

  AST_TX_NOT_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !rx_pulse_low && !$past(rx_pulse_low)); // R8
  AST_START_OUTSIDE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !rx_pulse_low); // R8
endmodule

// File: tb/sim_card_uart.sv
module sim_card_uart;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, conv_inverse, tx_enable, tx_write, rx_enable, rx_read, line_in;
  logic [3:0] baud_pre;
  logic [7:0] baud_div, tx_data;
  logic       tx_ready, rx_valid, line_out, tx_irq, rx_irq;
  logic       err_overrun, err_frame, err_parity, err_sum;
  logic [7:0] rx_data;

  card_uart u0 (.*);

  int n_chk = 0, n_bad = 0;
  int tx_irq_n = 0, rx_irq_n = 0, pulse_n = 0, low_run = 0;

  always @(posedge clk) begin
    if (tx_irq) tx_irq_n <= tx_irq_n + 1;
    if (rx_irq) rx_irq_n <= rx_irq_n + 1;
    if (!line_out) low_run <= low_run + 1;
    else begin
      if (low_run >= 15 && low_run <= 17) pulse_n <= pulse_n + 1;
      low_run <= 0;
    end
  end

  // {inverse, corrupt parity, corrupt stop, data}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'hA5}, {3'b100, 8'h3B}, {3'b010, 8'h00}, {3'b110, 8'hFF},
    {3'b001, 8'h5C}, {3'b101, 8'h81}, {3'b000, 8'hFF}, {3'b100, 8'h00}};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [10:0] want_frame(input logic inv, input logic [7:0] d);
    logic [10:0] f;
    logic par;
    par = 1'b0;
    for (int i = 0; i < 8; i++) par = par ^ d[i];
    if (inv) par = ~par;                  // odd: ones in data plus parity odd
    f[0]  = 1'b0;
    f[10] = 1'b1;
    for (int i = 0; i < 8; i++) f[1+i] = inv ? ~d[7-i] : d[i];
    f[9]  = inv ? ~par : par;
    return f;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic inv, input logic [7:0] d, input logic badp,
                            input logic bads, input int glitch_bit);
    logic [10:0] f;
    f = want_frame(inv, d);
    if (badp) f[9] = ~f[9];
    for (int i = 0; i < 10; i++) begin
      line_in = f[i];
      if (i == glitch_bit) begin
        tick(8); line_in = ~f[i]; tick(1); line_in = f[i]; tick(7);
      end else tick(16);
    end
    if (bads) begin line_in = 1'b0; tick(12); line_in = 1'b1; tick(4); end
    else begin line_in = 1'b1; tick(16); end
  endtask

  task automatic grab_tx(input int bitp, output logic [10:0] got);
    int t;
    t = 0;
    while (line_out && t < 5000) begin tick(1); t++; end
    tick(bitp / 2);
    for (int i = 0; i < 11; i++) begin
      got[i] = line_out;
      if (i < 10) tick(bitp);
    end
  endtask

  task automatic low_len(output int n);
    int t;
    t = 0;
    while (line_out && t < 5000) begin tick(1); t++; end
    n = 0;
    while (!line_out && n < 5000) begin tick(1); n++; end
  endtask

  task automatic wait_tx_irq(input int base);
    int t;
    t = 0;
    while (tx_irq_n == base && t < 5000) begin tick(1); t++; end
  endtask

  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_write = 1'b1; tick(1); tx_write = 1'b0;
  endtask

  task automatic read_rx();
    rx_read = 1'b1; tick(1); rx_read = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [10:0] got;
    int r0, t0, p0, n;
    rst_n = 1'b0; conv_inverse = 1'b0; baud_pre = 4'd0; baud_div = 8'd0;
    tx_enable = 1'b0; tx_write = 1'b0; tx_data = 8'h00;
    rx_enable = 1'b0; rx_read = 1'b0; line_in = 1'b1;
    tick(5); rst_n = 1'b1; tick(3);

    chk("R2", "reset line_out idle", line_out, 1);
    chk("R5", "reset tx_ready", tx_ready, 1);
    chk("R7", "reset rx_valid", rx_valid, 0);
    chk("R11", "reset err_sum", err_sum, 0);
    chk("R7", "reset irq count", rx_irq_n + tx_irq_n, 0);

    tx_enable = 1'b1; rx_enable = 1'b1;

    // table walk: receive then transmit each character
    for (int v = 0; v < 8; v++) begin
      logic inv, bp, bs;
      logic [7:0] d;
      {inv, bp, bs, d} = VEC[v];
      conv_inverse = inv; tick(4);
      r0 = rx_irq_n; p0 = pulse_n;
      send_frame(inv, d, bp, bs, -1);
      tick(40);
      chk(inv ? "R4" : "R3", "rx_data", rx_data, d);
      chk("R7", "rx_valid after char", rx_valid, 1);
      chk("R7", "rx_irq count", rx_irq_n - r0, 1);
      chk("R8", "err_parity", err_parity, bp);
      chk("R8", "error pulse count", pulse_n - p0, bp);
      chk("R9", "err_frame", err_frame, bs);
      chk("R11", "err_sum", err_sum, bp | bs);
      read_rx();
      chk("R7", "rx_valid after read", rx_valid, 0);
      t0 = tx_irq_n;
      write_tx(d);
      grab_tx(16, got);
      chk(inv ? "R4" : "R3", "tx frame (R2 order)", got, want_frame(inv, d));
      wait_tx_irq(t0);
      chk("R5", "tx_irq count", tx_irq_n - t0, 1);
      tick(20);
    end

    // R1 bit period: prescale 2 (div 4), divisor 1 -> 128 clocks
    conv_inverse = 1'b0; baud_pre = 4'd2; baud_div = 8'd1;
    t0 = tx_irq_n; write_tx(8'h01); low_len(n);
    chk("R1", "start bit clocks pre2 div1", n, 128);
    wait_tx_irq(t0); tick(10);
    baud_pre = 4'd1; baud_div = 8'd0;
    t0 = tx_irq_n; write_tx(8'h01); low_len(n);
    chk("R1", "start bit clocks pre1 div0", n, 32);
    wait_tx_irq(t0);
    baud_pre = 4'd0; tick(10);

    // R5 enable gating and write while full
    tx_enable = 1'b0; t0 = tx_irq_n;
    write_tx(8'h12);
    chk("R5", "tx_ready when full", tx_ready, 0);
    write_tx(8'h34);
    tick(60);
    chk("R5", "no frame while disabled", line_out, 1);
    tx_enable = 1'b1;
    grab_tx(16, got);
    chk("R5", "first write kept", got, want_frame(1'b0, 8'h12));
    wait_tx_irq(t0); tick(300);
    chk("R5", "ignored write not sent", tx_irq_n - t0, 1);
    chk("R5", "tx_ready after send", tx_ready, 1);

    // R6 receive enable, false start, majority vote
    rx_enable = 1'b0; r0 = rx_irq_n;
    send_frame(1'b0, 8'h77, 1'b0, 1'b0, -1); tick(40);
    chk("R6", "no irq while disabled", rx_irq_n - r0, 0);
    chk("R6", "no valid while disabled", rx_valid, 0);
    rx_enable = 1'b1;
    line_in = 1'b0; tick(3); line_in = 1'b1; tick(60);
    chk("R6", "short glitch rejected", rx_irq_n - r0, 0);
    send_frame(1'b0, 8'h6E, 1'b0, 1'b0, 4); tick(40);
    chk("R6", "vote masks one bad sample", rx_data, 8'h6E);
    chk("R6", "no parity error from glitch", err_parity, 0);
    read_rx();

    // R10 overrun
    r0 = rx_irq_n;
    send_frame(1'b0, 8'h11, 1'b0, 1'b0, -1); tick(20);
    send_frame(1'b0, 8'h22, 1'b0, 1'b0, -1); tick(40);
    chk("R10", "err_overrun", err_overrun, 1);
    chk("R10", "no irq on overrun", rx_irq_n - r0, 1);
    chk("R10", "rx_valid held", rx_valid, 1);
    chk("R11", "err_sum on overrun", err_sum, 1);
    read_rx();
    send_frame(1'b0, 8'h33, 1'b0, 1'b0, -1); tick(40);
    chk("R11", "overrun cleared at next char", err_overrun, 0);
    chk("R7", "data after overrun", rx_data, 8'h33);
    read_rx();

    // R8 collision: transmit requested while a parity failure is pending
    begin
      logic [10:0] f;
      f = want_frame(1'b0, 8'h4D);
      f[9] = ~f[9];
      for (int i = 0; i < 10; i++) begin line_in = f[i]; tick(16); end
      line_in = 1'b1;
      write_tx(8'h96);
      low_len(n);
      chk("R8", "error pulse length", n, 16);
      n = 0;
      while (line_out && n < 5000) begin tick(1); n++; end
      chk("R8", "guard gap at least one bit", (n >= 15) ? 1 : 0, 1);
      grab_tx(16, got);
      chk("R8", "deferred frame intact", got, want_frame(1'b0, 8'h96));
      chk("R8", "err_parity on collision", err_parity, 1);
      tick(40);
    end

    finish_run();
  end
endmodule